// File: doc/BRIEF.md
# Serial Port Control and Interrupt Gating

This block is the control and status layer that sits between a processor bus and a pair of serial shift engines, one for sending and one for receiving. It holds one eight-bit control register: three interrupt enables, separate enables for the receive and transmit sides, the high bit of the character-size code, and the ninth data bit for each direction. It forms three interrupt requests: receive complete, transmit complete and data register empty. Each request is the AND of its enable bit, a global interrupt enable and the matching status flag.

The block owns a one-word transmit holding buffer and a small receive buffer. Software writes the ninth transmit bit into the control register before it writes the low byte. The byte write copies that bit into the holding buffer with the byte. On the receive side, software reads the control register first to get the ninth received bit, then reads the low byte, which removes the entry. Clearing the transmit enable does not stop the transmitter at once. The transmitter keeps control of its pin until the holding buffer is empty and the shift engine reports that it is idle. Clearing the receive enable empties the receive buffer, and its error flags read zero from then on.

The character-size high bit combines with a two-bit field from a second register, outside this block, to give the frame length that both shift engines use.

Top module: `uart_ctl_gate`

## Requirements
- R1: `irq_rx` is high exactly when control bit 7, `gie` and `rx_ready` are all high. `irq_tx` is high exactly when control bit 6, `gie` and `tx_done` are all high. `irq_dre` is high exactly when control bit 5, `gie` and `dre_flag` are all high.
- R2: The control register bits are, from bit 7 down to bit 0: receive-complete interrupt enable, transmit-complete interrupt enable, data-empty interrupt enable, receive enable, transmit enable, size-code high bit, received bit 8, transmit bit 8. After reset `ctl_rdata` is 0x00. A write stores bits 7..2 and bit 0, which then read back unchanged.
- R3: Bit 1 of the control register cannot be written. It reads as bit 8 of the oldest received entry, and as 0 when the receive buffer is empty.
- R4: `data_bits` decodes the three-bit code {control bit 2, `size_lo`}: codes 0 to 3 give 5 to 8, code 7 gives 9, and codes 4 to 6 give 8.
- R5: An accepted `txd_wr` stores {transmit bit 8 at that moment, `txd_byte`} in the holding buffer. A later change to transmit bit 8 leaves the stored word unchanged.
- R6: `txd_wr` is accepted only while control bit 3 reads 1 and the holding buffer is empty. Any other `txd_wr` leaves the buffer unchanged.
- R7: `tx_pin_own` rises one cycle after control bit 3 reads 1. After the bit is cleared, it stays high while a word is pending or `tx_sr_busy` is high. It falls in the cycle after the cycle in which the buffer is empty and `tx_sr_busy` is low.
- R8: While control bit 4 reads 0, `rx_ready`, `rx_fe`, `rx_dor` and `rx_pe` are all 0. A frame that arrives while the bit is 0, or in the cycle in which the bit is being cleared, is discarded.
- R9: The receive buffer is first-in first-out and holds RX_DEPTH entries (default 2). `rxd_byte`, `rx_fe`, `rx_dor`, `rx_pe` and control bit 1 show the oldest entry, and reading them has no effect. A pulse on `rxd_rd` removes that entry. A frame that arrives while the buffer is full and no entry is being removed is discarded. A removal and an arrival in the same cycle are both honoured.
- R10: `dre_flag` is 1 exactly when the transmit holding buffer is empty. `tx_pend_valid` is 1 only while a word is held and `tx_pin_own` is high. `tx_pend_data` is {bit 8, low byte}, and `tx_take` empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| size_lo | input | 2 | Low two bits of the size code, from the format register |
| data_bits | output | 4 | Data bits per frame (5 to 9) |
| gie | input | 1 | Global interrupt enable |
| txd_wr | input | 1 | Transmit low-byte write strobe |
| txd_byte | input | 8 | Transmit low byte |
| tx_pend_valid | output | 1 | Holding buffer has a word for the shift engine |
| tx_pend_data | output | 9 | Held word {bit 8, low byte} |
| tx_take | input | 1 | Shift engine takes the held word |
| tx_sr_busy | input | 1 | Transmit shift register still holds a frame |
| tx_pin_own | output | 1 | Transmitter overrides the TX pin |
| tx_done | input | 1 | Transmit-complete status flag |
| rx_frame_valid | input | 1 | Receive engine delivers a frame |
| rx_frame_data | input | 9 | Delivered frame {bit 8, low byte} |
| rx_frame_fe | input | 1 | Frame error of delivered frame |
| rx_frame_dor | input | 1 | Data overrun of delivered frame |
| rx_frame_pe | input | 1 | Parity error of delivered frame |
| rxd_rd | input | 1 | Read of the received low byte (removes the entry) |
| rxd_byte | output | 8 | Oldest received low byte |
| rx_ready | output | 1 | Receive buffer not empty |
| rx_fe | output | 1 | Frame error of oldest entry |
| rx_dor | output | 1 | Data overrun of oldest entry |
| rx_pe | output | 1 | Parity error of oldest entry |
| dre_flag | output | 1 | Transmit holding buffer empty |
| irq_rx | output | 1 | Receive-complete interrupt request |
| irq_tx | output | 1 | Transmit-complete interrupt request |
| irq_dre | output | 1 | Data-register-empty interrupt request |

## Verification
Two receive-side events can fall in the same cycle: the control write that clears the receive enable, and a frame arriving from the engine. The bench drives both in one cycle and expects the flush to win. After that cycle the buffer must be empty with all error flags at zero, and it must still be empty once the enable is set again. In the same cycle pattern, a low-byte read together with a new arrival must leave one entry, and that entry must be the new frame. On the transmit side, a byte write is attempted while the shutdown is pending. The pin override is sampled just before and just after the edge at which the shift engine goes idle, which pins down the single cycle in which it falls.

// File: rtl/uctl_pkg.sv
package uctl_pkg;

    localparam int CTL_W      = 8;
    localparam int BIT_RXC_IE = 7;
    localparam int BIT_TXC_IE = 6;
    localparam int BIT_DRE_IE = 5;
    localparam int BIT_RX_EN  = 4;
    localparam int BIT_TX_EN  = 3;
    localparam int BIT_SZ_HI  = 2;
    localparam int BIT_RX_B8  = 1;
    localparam int BIT_TX_B8  = 0;

    // stored control bits; received bit 8 is not stored here
    typedef struct packed {
        logic rxc_ie;
        logic txc_ie;
        logic dre_ie;
        logic rx_en;
        logic tx_en;
        logic size_hi;
        logic tx_b8;
    } ctl_t;

    typedef struct packed {
        logic       b8;
        logic [7:0] lo;
    } txword_t;

    typedef struct packed {
        logic       fe;
        logic       dor;
        logic       pe;
        logic       b8;
        logic [7:0] lo;
    } rxent_t;

    function automatic ctl_t ctl_from_bus(logic [CTL_W-1:0] d);
        ctl_t c;
        c.rxc_ie  = d[BIT_RXC_IE];
        c.txc_ie  = d[BIT_TXC_IE];
        c.dre_ie  = d[BIT_DRE_IE];
        c.rx_en   = d[BIT_RX_EN];
        c.tx_en   = d[BIT_TX_EN];
        c.size_hi = d[BIT_SZ_HI];
        c.tx_b8   = d[BIT_TX_B8];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_to_bus(ctl_t c, logic rx_b8);
        logic [CTL_W-1:0] d;
        d             = '0;
        d[BIT_RXC_IE] = c.rxc_ie;
        d[BIT_TXC_IE] = c.txc_ie;
        d[BIT_DRE_IE] = c.dre_ie;
        d[BIT_RX_EN]  = c.rx_en;
        d[BIT_TX_EN]  = c.tx_en;
        d[BIT_SZ_HI]  = c.size_hi;
        d[BIT_RX_B8]  = rx_b8;
        d[BIT_TX_B8]  = c.tx_b8;
        return d;
    endfunction

    // size code -> data bits per frame; reserved codes fall back to 8
    function automatic logic [3:0] frame_bits(logic [2:0] code);
        logic [3:0] n;
        case (code)
            3'd0:    n = 4'd5;
            3'd1:    n = 4'd6;
            3'd2:    n = 4'd7;
            3'd3:    n = 4'd8;
            3'd7:    n = 4'd9;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/uctl_regs.sv
module uctl_regs
    import uctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic [1:0]       size_lo,
    output ctl_t             ctl,
    output logic [3:0]       data_bits,
    output logic             rx_flush
);
    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= ctl_from_bus(wr_data);
        end
    end

    assign ctl       = ctl_q;
    assign data_bits = frame_bits({ctl_q.size_hi, size_lo});
    // the receive buffer is held empty while disabled and in the clearing cycle
    assign rx_flush  = !ctl_q.rx_en || (wr_en && !wr_data[BIT_RX_EN]);

endmodule

// File: rtl/uctl_tx_stage.sv
module uctl_tx_stage
    import uctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       tx_b8,
    input  logic       wr,
    input  logic [7:0] wr_byte,
    input  logic       take,
    input  logic       sr_busy,
    output logic       pend_valid,
    output txword_t    pend,
    output logic       own,
    output logic       buf_empty
);
    txword_t hold_q;
    logic    hold_v;
    logic    own_q;
    logic    accept;

    assign accept = wr && tx_en && !hold_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            hold_v <= 1'b0;
            own_q  <= 1'b0;
        end else begin
            if (accept) begin
                hold_q <= '{b8: tx_b8, lo: wr_byte};
                hold_v <= 1'b1;
            end else if (take && hold_v && own_q) begin
                hold_v <= 1'b0;
            end
            // deferred shutdown: keep the pin until buffer and shifter drain
            own_q <= tx_en || (own_q && (hold_v || sr_busy));
        end
    end

    assign pend_valid = hold_v && own_q;
    assign pend       = hold_q;
    assign own        = own_q;
    assign buf_empty  = !hold_v;

endmodule

// File: rtl/uctl_rx_stage.sv
module uctl_rx_stage
    import uctl_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   in_valid,
    input  rxent_t in_ent,
    input  logic   pop,
    output logic   ready,
    output rxent_t head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rxent_t          mem [DEPTH];
    logic [PW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            empty, full, do_pop, do_push;

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_pop  = pop && !empty && !flush;
    assign do_push = in_valid && !flush && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= in_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign ready = !empty;
    assign head  = empty ? '0 : mem[rp];

endmodule

// File: rtl/uctl_irq_gate.sv
module uctl_irq_gate
    import uctl_pkg::*;
(
    input  ctl_t ctl,
    input  logic gie,
    input  logic rx_ready,
    input  logic tx_done,
    input  logic dre,
    output logic irq_rx,
    output logic irq_tx,
    output logic irq_dre
);
    assign irq_rx  = gie && ctl.rxc_ie && rx_ready;
    assign irq_tx  = gie && ctl.txc_ie && tx_done;
    assign irq_dre = gie && ctl.dre_ie && dre;
endmodule

// File: rtl/uart_ctl_gate.sv
module uart_ctl_gate
    import uctl_pkg::*;
#(
    parameter int RX_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic [1:0] size_lo,
    output logic [3:0] data_bits,
    input  logic       gie,
    input  logic       txd_wr,
    input  logic [7:0] txd_byte,
    output logic       tx_pend_valid,
    output logic [8:0] tx_pend_data,
    input  logic       tx_take,
    input  logic       tx_sr_busy,
    output logic       tx_pin_own,
    input  logic       tx_done,
    input  logic       rx_frame_valid,
    input  logic [8:0] rx_frame_data,
    input  logic       rx_frame_fe,
    input  logic       rx_frame_dor,
    input  logic       rx_frame_pe,
    input  logic       rxd_rd,
    output logic [7:0] rxd_byte,
    output logic       rx_ready,
    output logic       rx_fe,
    output logic       rx_dor,
    output logic       rx_pe,
    output logic       dre_flag,
    output logic       irq_rx,
    output logic       irq_tx,
    output logic       irq_dre
);
    ctl_t    ctl;
    logic    rx_flush;
    txword_t tx_word;
    rxent_t  rx_in, rx_head;

    uctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ctl_wr),
        .wr_data   (ctl_wdata),
        .size_lo   (size_lo),
        .ctl       (ctl),
        .data_bits (data_bits),
        .rx_flush  (rx_flush)
    );

    uctl_tx_stage u_tx (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (ctl.tx_en),
        .tx_b8      (ctl.tx_b8),
        .wr         (txd_wr),
        .wr_byte    (txd_byte),
        .take       (tx_take),
        .sr_busy    (tx_sr_busy),
        .pend_valid (tx_pend_valid),
        .pend       (tx_word),
        .own        (tx_pin_own),
        .buf_empty  (dre_flag)
    );

    assign tx_pend_data = {tx_word.b8, tx_word.lo};

    assign rx_in = '{fe: rx_frame_fe, dor: rx_frame_dor, pe: rx_frame_pe,
                     b8: rx_frame_data[8], lo: rx_frame_data[7:0]};

    uctl_rx_stage #(.DEPTH(RX_DEPTH)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .flush    (rx_flush),
        .in_valid (rx_frame_valid),
        .in_ent   (rx_in),
        .pop      (rxd_rd),
        .ready    (rx_ready),
        .head     (rx_head)
    );

    assign rxd_byte  = rx_head.lo;
    assign rx_fe     = rx_head.fe;
    assign rx_dor    = rx_head.dor;
    assign rx_pe     = rx_head.pe;
    assign ctl_rdata = ctl_to_bus(ctl, rx_head.b8);

    uctl_irq_gate u_irq (
        .ctl      (ctl),
        .gie      (gie),
        .rx_ready (rx_ready),
        .tx_done  (tx_done),
        .dre      (dre_flag),
        .irq_rx   (irq_rx),
        .irq_tx   (irq_tx),
        .irq_dre  (irq_dre)
    );

endmodule

// File: rtl/uart_ctl_gate_chk.sv
module uart_ctl_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic [7:0] ctl_rdata,
    input logic [3:0] data_bits,
    input logic       gie,
    input logic       tx_done,
    input logic       tx_pend_valid,
    input logic       tx_sr_busy,
    input logic       tx_pin_own,
    input logic       rx_ready,
    input logic       rx_fe,
    input logic       rx_dor,
    input logic       rx_pe,
    input logic       dre_flag,
    input logic       irq_rx,
    input logic       irq_tx,
    input logic       irq_dre
);
    // R1
    irq_rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> (gie && ctl_rdata[7] && rx_ready));
    // R1
    irq_tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_tx |-> (gie && ctl_rdata[6] && tx_done));
    // R1
    irq_dre_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_dre |-> (gie && ctl_rdata[5] && dre_flag));
    // R1
    irq_off_chk: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !(irq_rx || irq_tx || irq_dre));
    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctl_rdata == 8'h00));
    // R4
    bits_range_chk: assert property (@(posedge clk) disable iff (rst)
        (data_bits >= 4'd5) && (data_bits <= 4'd9));
    // R7
    own_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_pin_own && (tx_pend_valid || tx_sr_busy)) |=> tx_pin_own);
    // R7
    own_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_rdata[3] && !tx_pend_valid && !tx_sr_busy && !(ctl_wr && ctl_wdata[3]))
        |=> !tx_pin_own);
    // R10
    pend_needs_own_chk: assert property (@(posedge clk) disable iff (rst)
        tx_pend_valid |-> (tx_pin_own && !dre_flag));
    // R8
    rx_flushed_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[4] |-> !(rx_ready || rx_fe || rx_dor || rx_pe));
endmodule

bind uart_ctl_gate uart_ctl_gate_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ctl_wr        (ctl_wr),
    .ctl_wdata     (ctl_wdata),
    .ctl_rdata     (ctl_rdata),
    .data_bits     (data_bits),
    .gie           (gie),
    .tx_done       (tx_done),
    .tx_pend_valid (tx_pend_valid),
    .tx_sr_busy    (tx_sr_busy),
    .tx_pin_own    (tx_pin_own),
    .rx_ready      (rx_ready),
    .rx_fe         (rx_fe),
    .rx_dor        (rx_dor),
    .rx_pe         (rx_pe),
    .dre_flag      (dre_flag),
    .irq_rx        (irq_rx),
    .irq_tx        (irq_tx),
    .irq_dre       (irq_dre)
);

// File: tb/uart_ctl_gate_bench.sv
module uart_ctl_gate_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_wr;
    logic [7:0] ctl_wdata;
    logic [7:0] ctl_rdata;
    logic [1:0] size_lo;
    logic [3:0] data_bits;
    logic       gie;
    logic       txd_wr;
    logic [7:0] txd_byte;
    logic       tx_pend_valid;
    logic [8:0] tx_pend_data;
    logic       tx_take;
    logic       tx_sr_busy;
    logic       tx_pin_own;
    logic       tx_done;
    logic       rx_frame_valid;
    logic [8:0] rx_frame_data;
    logic       rx_frame_fe, rx_frame_dor, rx_frame_pe;
    logic       rxd_rd;
    logic [7:0] rxd_byte;
    logic       rx_ready, rx_fe, rx_dor, rx_pe;
    logic       dre_flag, irq_rx, irq_tx, irq_dre;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_ctl_gate u_uart_ctl_gate (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl_write(logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic rx_push(logic [8:0] d, logic fe, logic dor, logic pe);
        rx_frame_valid = 1'b1; rx_frame_data = d;
        rx_frame_fe = fe; rx_frame_dor = dor; rx_frame_pe = pe;
        tick();
        rx_frame_valid = 1'b0; rx_frame_fe = 0; rx_frame_dor = 0; rx_frame_pe = 0;
    endtask

    task automatic tx_write(logic [7:0] b);
        txd_wr = 1'b1; txd_byte = b;
        tick();
        txd_wr = 1'b0;
    endtask

    task automatic rx_pop();
        rxd_rd = 1'b1;
        tick();
        rxd_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctl_wr = 0; ctl_wdata = 0; size_lo = 0; gie = 0;
        txd_wr = 0; txd_byte = 0; tx_take = 0; tx_sr_busy = 0; tx_done = 0;
        rx_frame_valid = 0; rx_frame_data = 0; rx_frame_fe = 0;
        rx_frame_dor = 0; rx_frame_pe = 0; rxd_rd = 0;
        tick(); tick();
        rst = 1'b0;
        #1;
        // R2 reset value
        chk("R2 reset ctl", ctl_rdata, 8'h00);
        chk("R10 reset dre", dre_flag, 1'b1);
        chk("R7 reset own", tx_pin_own, 1'b0);

        // R1 R2 R3 R10: sweep every control value against gie and tx_done
        for (int v = 0; v < 256; v++) begin
            ctl_write(8'(v));
            for (int g = 0; g < 2; g++) begin
                for (int t = 0; t < 2; t++) begin
                    gie = g[0]; tx_done = t[0];
                    #1;
                    chk("R2 R3 readback", ctl_rdata, 8'(v) & 8'hFD);
                    chk("R10 dre empty", dre_flag, 1'b1);
                    chk("R1 irq_tx", irq_tx, 32'(v >> 6 & 1 & g & t));
                    chk("R1 irq_dre", irq_dre, 32'(v >> 5 & 1 & g));
                    chk("R1 irq_rx empty", irq_rx, 1'b0);
                end
            end
        end
        gie = 0; tx_done = 0;

        // R4 sweep of the size code
        for (int c = 0; c < 8; c++) begin
            size_lo = 2'(c);
            ctl_write(8'(c & 4));
            chk("R4 data_bits", data_bits,
                (c < 4) ? 32'(5 + c) : ((c == 7) ? 32'd9 : 32'd8));
        end
        size_lo = 0;

        // R9 receive order and depth
        ctl_write(8'h90);
        gie = 1'b1;
        rx_push(9'h13C, 1, 0, 0);
        chk("R9 ready", rx_ready, 1);
        chk("R1 irq_rx set", irq_rx, 1);
        chk("R3 rx b8", ctl_rdata[1], 1);
        chk("R9 head byte", rxd_byte, 8'h3C);
        chk("R9 head fe", rx_fe, 1);
        tick();
        chk("R9 read no side effect", rxd_byte, 8'h3C);
        rx_push(9'h055, 0, 0, 1);
        rx_push(9'h177, 0, 1, 0);
        rx_pop();
        chk("R9 second byte", rxd_byte, 8'h55);
        chk("R9 second b8", ctl_rdata[1], 0);
        chk("R9 second pe", rx_pe, 1);
        chk("R9 second fe", rx_fe, 0);
        rx_pop();
        chk("R9 full drop", rx_ready, 0);
        chk("R1 irq_rx clear", irq_rx, 0);
        chk("R3 empty b8", ctl_rdata[1], 0);

        // R9 pop and push in one cycle
        rx_push(9'h011, 0, 0, 0);
        rxd_rd = 1'b1;
        rx_push(9'h122, 0, 1, 0);
        rxd_rd = 1'b0;
        chk("R9 swap ready", rx_ready, 1);
        chk("R9 swap byte", rxd_byte, 8'h22);
        chk("R9 swap dor", rx_dor, 1);
        rx_pop();
        chk("R9 swap single", rx_ready, 0);

        // R8 flush collides with arrival
        rx_push(9'h1AA, 1, 1, 1);
        rx_frame_valid = 1'b1; rx_frame_data = 9'h0BB; rx_frame_pe = 1;
        ctl_write(8'h80);
        rx_frame_valid = 1'b0; rx_frame_pe = 0;
        chk("R8 flushed ready", rx_ready, 0);
        chk("R8 flushed flags", {rx_fe, rx_dor, rx_pe}, 3'b000);
        rx_push(9'h0CC, 0, 0, 0);
        ctl_write(8'h90);
        chk("R8 still empty", rx_ready, 0);
        ctl_write(8'h00);

        // R5 R6 R7 R10 transmit path
        ctl_write(8'h08);
        chk("R7 own delayed", tx_pin_own, 0);
        tick();
        chk("R7 own set", tx_pin_own, 1);
        ctl_write(8'h29);
        chk("R1 irq_dre", irq_dre, 1);
        tx_write(8'hA5);
        chk("R10 pend valid", tx_pend_valid, 1);
        chk("R5 pend data", tx_pend_data, 9'h1A5);
        chk("R10 dre full", dre_flag, 0);
        ctl_write(8'h28);
        chk("R5 latched b8", tx_pend_data, 9'h1A5);
        tx_write(8'h3C);
        chk("R6 full ignore", tx_pend_data, 9'h1A5);
        ctl_write(8'h00);
        chk("R7 own kept pending", tx_pin_own, 1);
        tx_take = 1'b1;
        tick();
        tx_take = 1'b0; tx_sr_busy = 1'b1;
        chk("R10 taken", tx_pend_valid, 0);
        chk("R10 dre after take", dre_flag, 1);
        tx_write(8'h22);
        chk("R6 disabled ignore", dre_flag, 1);
        tick();
        chk("R7 own busy", tx_pin_own, 1);
        tx_sr_busy = 1'b0;
        #1;
        chk("R7 own last cycle", tx_pin_own, 1);
        tick();
        chk("R7 own dropped", tx_pin_own, 0);
        chk("R10 no pend", tx_pend_valid, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule